// File: doc/BRIEF.md
# Dual Selectable Clock Divider with Freeze

The block takes one input clock and produces two divided clocks from it. Output A runs at the input rate or at one half, one quarter or one eighth of it. Output B runs at one half, one quarter, one eighth or one sixteenth of it. Each output has its own 2-bit ratio select. Both outputs come from a single shared counter, so every edge they have in common lands on the same input edge. This lets a system derive several related clocks that stay in phase with each other.

A freeze input stops the divider without glitches. It is captured on the falling input edge, so the internal enable only changes while the input clock is low. An asynchronous active-low reset drives both outputs low at once. Several copies of the block that leave reset together produce their first high level on the same rising input edge, which keeps them aligned to each other.

Top module: `clkdiv_dual`

## Requirements
- R1: Output A ratio follows sel_a: 0 passes the input clock through, 1 divides by 2, 2 by 4, 3 by 8. A divided output is high for the first half of its period, counted in rising input edges since the last reset.
- R2: Output B ratio follows sel_b: 0 divides by 2, 1 by 4, 2 by 8, 3 by 16, with the same phase rule as R1.
- R3: Every 16 counted rising edges after reset, both outputs go high on the same rising edge.
- R4: While frozen, divided outputs keep their level and the pass-through output A stays low.
- R5: hold is sampled on the falling input edge. Setting it freezes the divider from the next rising edge. Clearing it resumes counting at the next count value, on the first rising edge after the following falling edge.
- R6: rst_n low forces out_a and out_b low at once, without waiting for a clock edge.
- R7: After rst_n is released, both outputs go high on the first rising input edge, for every ratio.
- R8: A new divided ratio on either select takes effect on the next counted rising edge, with its phase taken from the running count.
- R9: Outside reset, freezing and resuming never produce a high pulse on either output shorter than half an input period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | Freeze request, high stops the divider |
| sel_a | input | 2 | Ratio select for output A |
| sel_b | input | 2 | Ratio select for output B |
| out_a | output | 1 | Divided clock A (ratio 1, 2, 4 or 8) |
| out_b | output | 1 | Divided clock B (ratio 2, 4, 8 or 16) |

## Verification
A wrong counter value moves the phase of every divided output. It shows on the first counted rising edge whose expected level differs, at most eight edges later for the slowest ratio. A wrong freeze enable shows up as a divided output that changes level while it should hold. With the pass-through ratio it shows up sooner, as a high level during a frozen high phase, or as a shortened high pulse when the enable flips while the clock is high. A broken reset path shows up either as a non-low output straight after reset is asserted, or as an output that fails to rise on the first edge after release.

// File: rtl/clkdiv_dual.sv
module clkdiv_dual (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic       hold,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_b,
  output logic       out_a,
  output logic       out_b
);
  localparam int CNT_W = 4;

  logic             run_en;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic [1:0]       sel_a_q;
  logic             qa_r;
  logic             qb_r;

  always_ff @(negedge clk_in or negedge rst_n)
    if (!rst_n) run_en <= 1'b1;
    else        run_en <= ~hold;

  assign cnt_nx = cnt + 1'b1;

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '1;
      sel_a_q <= 2'd0;
      qa_r    <= 1'b0;
      qb_r    <= 1'b0;
    end else if (run_en) begin
      cnt     <= cnt_nx;
      sel_a_q <= sel_a;
      qa_r    <= (sel_a == 2'd0) ? 1'b0 : ~cnt_nx[sel_a - 2'd1];
      qb_r    <= ~cnt_nx[sel_b];
    end

  assign out_a = (sel_a_q == 2'd0) ? (clk_in & run_en & rst_n) : qa_r;
  assign out_b = qb_r;
endmodule

// File: rtl/clkdiv_dual_chk.sv
module clkdiv_dual_chk (
  input logic       clk_in,
  input logic       rst_n,
  input logic       hold,
  input logic       run_en,
  input logic [3:0] cnt,
  input logic       qa_r,
  input logic       qb_r,
  input logic       out_a,
  input logic       out_b
);
  // R6
  rst_low_chk: assert property (@(posedge clk_in) !rst_n |-> (!out_a && !out_b));

  // R4
  freeze_cnt_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !run_en |=> $stable(cnt));

  // R4
  freeze_out_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !run_en |=> ($stable(qa_r) && $stable(qb_r)));

  // R1
  count_step_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    run_en |=> cnt == $past(cnt) + 4'd1);

  // R5
  hold_capture_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
    hold |=> !run_en);

  // R3
  wrap_align_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_en && cnt == 4'hF) |=> (qb_r && out_b));
endmodule

bind clkdiv_dual clkdiv_dual_chk chk (
  .clk_in(clk_in), .rst_n(rst_n), .hold(hold), .run_en(run_en), .cnt(cnt),
  .qa_r(qa_r), .qb_r(qb_r), .out_a(out_a), .out_b(out_b)
);

// File: tb/clkdiv_dual_test.sv
`timescale 1ns/1ps
module clkdiv_dual_test;
  localparam int P = 10;

  logic clk_in, rst_n, hold;
  logic [1:0] sel_a, sel_b;
  logic out_a, out_b;

  clkdiv_dual uut (.clk_in(clk_in), .rst_n(rst_n), .hold(hold), .sel_a(sel_a),
                   .sel_b(sel_b), .out_a(out_a), .out_b(out_b));

  int nchk = 0, nfail = 0;
  int k;
  bit mrun, prun, chg;
  logic [1:0] msa, msb;

  initial clk_in = 1'b0;
  always #(P/2) clk_in = ~clk_in;

  time ta_t, tb_t;
  bit  ta_ok, tb_ok;
  int  short_a = 0, short_b = 0;
  always @(posedge out_a) begin ta_t = $time; ta_ok = rst_n; end
  always @(negedge out_a) if (ta_ok && rst_n && ($time - ta_t) < P/2) short_a++;
  always @(posedge out_b) begin tb_t = $time; tb_ok = rst_n; end
  always @(negedge out_b) if (tb_ok && rst_n && ($time - tb_t) < P/2) short_b++;

  function automatic bit divx(int kk, int n);
    return ((kk - 1) % n) < (n / 2);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] sa, input logic [1:0] sb);
    rst_n = 1'b0;
    #1;
    chk("R6", out_a, 1'b0);
    chk("R6", out_b, 1'b0);
    sel_a = sa; sel_b = sb; hold = 1'b0;
    repeat (2) @(negedge clk_in);
    #2;
    rst_n = 1'b1;
    k = 0; mrun = 1'b1; prun = 1'b1; msa = 2'd0; msb = 2'd0;
  endtask

  task automatic step(input bit rnd);
    bit gated;
    string ta, tb;
    @(posedge clk_in);
    gated = mrun;
    chg = 1'b0;
    if (gated) begin
      k++;
      chg = (sel_a != msa) || (sel_b != msb);
      msa = sel_a; msb = sel_b;
    end
    #2;
    if (k == 1)                  begin ta = "R7"; tb = "R7"; end
    else if (!mrun)              begin ta = "R4"; tb = "R4"; end
    else if (!prun)              begin ta = "R5"; tb = "R5"; end
    else if (chg)                begin ta = "R8"; tb = "R8"; end
    else                         begin ta = "R1"; tb = "R2"; end
    prun = mrun;
    if (msa == 2'd0) chk(ta, out_a, mrun);
    else             chk(ta, out_a, divx(k, 1 << msa));
    chk(tb, out_b, divx(k, 2 << msb));
    if (gated && ((k - 1) % 16 == 0)) chk("R3", out_a & out_b, 1'b1);
    if (rnd && $urandom_range(7) == 0) hold = ~hold;
    @(negedge clk_in);
    mrun = !hold;
    #2;
    if (msa == 2'd0) chk("R4", out_a, 1'b0);
    else             chk("R1", out_a, divx(k, 1 << msa));
    chk("R2", out_b, divx(k, 2 << msb));
    if (rnd && $urandom_range(15) == 0) begin
      sel_a = 2'($urandom_range(3, 1));
      sel_b = 2'($urandom_range(3));
    end
  endtask

  initial begin
    #(P * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; hold = 1'b0; sel_a = 2'd0; sel_b = 2'd0;
    #(P * 2 + 2);
    for (int sa = 0; sa < 4; sa++)
      for (int sb = 0; sb < 4; sb++) begin
        do_reset(2'(sa), 2'(sb));
        repeat (36) step(1'b0);
        hold = 1'b1;
        repeat (5) step(1'b0);
        hold = 1'b0;
        repeat (12) step(1'b0);
      end
    do_reset(2'd2, 2'd1);
    for (int i = 0; i < 2500; i++) begin
      if (i % 400 == 399) begin
        @(posedge clk_in);
        #2;
        rst_n = 1'b0;
        #1;
        chk("R6", out_a, 1'b0);
        chk("R6", out_b, 1'b0);
        do_reset(2'($urandom_range(3, 1)), 2'($urandom_range(3)));
      end
      step(1'b1);
    end
    chk("R9", short_a == 0, 1'b1);
    chk("R9", short_b == 0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule